// File: doc/BRIEF.md
# Strobed Byte Bus Master

This block runs 16-bit register reads and writes on a narrow, byte-wide strobed target bus entirely in hardware. A requester presents an 8-bit register address, a 16-bit write value, a direction flag and a one-clock start pulse. The master then produces the whole pin sequence on the bus. It first sets the transfer direction. It then sends the address byte with the address-latch line high, and moves two value bytes, high byte first. Each byte goes through a fixed clear, set and strobe pattern. When the bytes are done, the master releases the active-low select line and samples the target's wait line to learn whether the target has finished.

If the target is still working, the master recovers according to the direction. A write is retried by pulsing select low and then high, followed by a new wait sample. A read repeats both data-byte strobes, and only the last attempt's data is returned. A parameter caps the number of retries. A target that is still waiting after the cap ends the request with an error flag. Every pin state is held for a parameter number of clocks, so a slow target sees the setup and hold time it needs. When the request completes, the master returns the pins to idle with the data lines driven high, and gives a one-clock done pulse.

Top module: `strobe_bus_master`

## Requirements
- R1: After reset and whenever idle, the master drives bus_sel_n=1, bus_stb=0, bus_lat=0, bus_doe=1, bus_dout=8'hFF, and busy=0, done=0, error=0. rdata resets to 0.
- R2: req_start is accepted only while idle. A start pulse during a transaction has no effect on any pin or on the result.
- R3: On acceptance, bus_dir becomes req_write (1 = write, 0 = read). It holds that value for the whole transaction. The first HOLD_CLKS clocks keep all other pins at idle levels.
- R4: Every byte cycle begins with a clear phase: bus_sel_n=0, bus_stb=0, bus_lat=0 and bus_dout=0. This is followed by a set phase and then a strobe phase with bus_stb=1. Each phase lasts HOLD_CLKS clocks.
- R5: The address byte is the first byte. It is driven on bus_dout with bus_lat=1 from its set phase through its strobe phase. Value bytes keep bus_lat=0.
- R6: A write drives req_wdata[15:8] in the set and strobe phases of the first value byte, and req_wdata[7:0] in the second.
- R7: A read sets bus_doe=0 from the clear phase of the first value byte onward. It samples bus_din on the last clock of each strobe phase, high byte first, then low byte.
- R8: After the second value byte, bus_sel_n rises with bus_stb still 1 for HOLD_CLKS clocks. bus_wait is sampled on the last of those clocks, and 0 means complete.
- R9: A write that sees bus_wait=1 drives bus_sel_n=0 for HOLD_CLKS clocks, then repeats the R8 phase.
- R10: A read that sees bus_wait=1 repeats both value-byte cycles (clear, set, strobe) and then the R8 phase. rdata returns the bytes of the final attempt.
- R11: If bus_wait=1 is seen when MAX_RETRY retries have already been made, the request ends with error=1 for one clock, together with done.
- R12: Completion gives done=1 for exactly one clock with busy=0, and the pins return to idle levels in that same clock. rdata changes only in that clock, and only for reads.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| req_start | input | 1 | One-clock request pulse |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | 8 | Register address |
| req_wdata | input | 16 | Write value |
| busy | output | 1 | Transaction in progress |
| done | output | 1 | One-clock completion pulse |
| error | output | 1 | Retry limit exceeded, with done |
| rdata | output | 16 | Last read result |
| bus_dout | output | 8 | Data bus output value |
| bus_doe | output | 1 | Data bus output enable |
| bus_din | input | 8 | Data bus input value |
| bus_sel_n | output | 1 | Active-low target select |
| bus_dir | output | 1 | Transfer direction |
| bus_stb | output | 1 | Byte strobe |
| bus_lat | output | 1 | Address latch enable |
| bus_wait | input | 1 | Target still busy |

## Verification
A wrong sequencer state shows up on the bus pins within HOLD_CLKS clocks. A skipped or repeated phase shifts every later pin edge, and the bench compares all pins every cycle against a phase list it builds from the requirements. A miscounted retry changes how many select pulses or read repeats appear before done, and changes whether error rises. A byte captured at the wrong strobe is visible in rdata in the done clock, because each read attempt is answered with distinct data.

// File: rtl/sbm_pkg.sv
package sbm_pkg;
    localparam int BYTE_W = 8;
    localparam int WORD_W = 2 * BYTE_W;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_TURN,
        ST_CLR,
        ST_SET,
        ST_STB,
        ST_CHK,
        ST_PULSE
    } seq_st_e;

    typedef enum logic [1:0] {
        BY_ADDR,
        BY_HI,
        BY_LO
    } byte_sel_e;

    typedef struct packed {
        seq_st_e             st;
        byte_sel_e           by;
        logic                wr;
        logic [BYTE_W-1:0]   addr;
        logic [WORD_W-1:0]   wdata;
        logic [WORD_W-1:0]   rd_acc;
        logic [WORD_W-1:0]   rdata;
        logic                dir;
        logic                sel_n;
        logic                stb;
        logic                lat;
        logic                doe;
        logic [BYTE_W-1:0]   dout;
        logic                done;
        logic                err;
    } seq_reg_t;
endpackage

// File: rtl/sbm_hold_timer.sv
module sbm_hold_timer #(
    parameter int HOLD_CLKS = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic restart,
    output logic last
);
    localparam int CW = (HOLD_CLKS > 1) ? $clog2(HOLD_CLKS) : 1;
    localparam logic [CW-1:0] LAST_V = CW'(HOLD_CLKS - 1);

    logic [CW-1:0] cnt_q, cnt_d;

    assign last = (cnt_q == LAST_V);

    always_comb begin
        if (restart)      cnt_d = '0;
        else if (last)    cnt_d = cnt_q;
        else              cnt_d = cnt_q + 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cnt_q <= '0;
        else        cnt_q <= cnt_d;
    end
endmodule

// File: rtl/sbm_retry_count.sv
module sbm_retry_count #(
    parameter int MAX_RETRY = 3
) (
    input  logic clk,
    input  logic rst_n,
    input  logic clr,
    input  logic inc,
    output logic at_limit
);
    localparam int RW = (MAX_RETRY > 0) ? $clog2(MAX_RETRY + 1) : 1;
    localparam logic [RW-1:0] LIM_V = RW'(MAX_RETRY);

    logic [RW-1:0] cnt_q, cnt_d;

    assign at_limit = (cnt_q == LIM_V);

    always_comb begin
        if (clr)                   cnt_d = '0;
        else if (inc && !at_limit) cnt_d = cnt_q + 1'b1;
        else                       cnt_d = cnt_q;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cnt_q <= '0;
        else        cnt_q <= cnt_d;
    end
endmodule

// File: rtl/sbm_sequencer.sv
module sbm_sequencer
    import sbm_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_start,
    input  logic              req_write,
    input  logic [BYTE_W-1:0] req_addr,
    input  logic [WORD_W-1:0] req_wdata,
    input  logic [BYTE_W-1:0] bus_din,
    input  logic              bus_wait,
    input  logic              ph_last,
    input  logic              retry_at_limit,
    output logic              ph_restart,
    output logic              retry_clr,
    output logic              retry_inc,
    output logic              busy,
    output logic              done,
    output logic              error,
    output logic [WORD_W-1:0] rdata,
    output logic [BYTE_W-1:0] bus_dout,
    output logic              bus_doe,
    output logic              bus_sel_n,
    output logic              bus_dir,
    output logic              bus_stb,
    output logic              bus_lat
);
    seq_reg_t q, d;
    logic     finish;
    logic     fin_err;

    always_comb begin
        d          = q;
        d.done     = 1'b0;
        d.err      = 1'b0;
        ph_restart = 1'b0;
        retry_clr  = 1'b0;
        retry_inc  = 1'b0;
        finish     = 1'b0;
        fin_err    = 1'b0;

        case (q.st)
            ST_IDLE: begin
                if (req_start) begin
                    d.st       = ST_TURN;
                    d.wr       = req_write;
                    d.addr     = req_addr;
                    d.wdata    = req_wdata;
                    d.dir      = req_write;
                    ph_restart = 1'b1;
                    retry_clr  = 1'b1;
                end
            end
            ST_TURN: begin
                if (ph_last) begin
                    d.st       = ST_CLR;
                    d.by       = BY_ADDR;
                    d.sel_n    = 1'b0;
                    d.stb      = 1'b0;
                    d.lat      = 1'b0;
                    d.dout     = '0;
                    ph_restart = 1'b1;
                end
            end
            ST_CLR: begin
                if (ph_last) begin
                    d.st       = ST_SET;
                    ph_restart = 1'b1;
                    if (q.by == BY_ADDR) begin
                        d.lat  = 1'b1;
                        d.dout = q.addr;
                    end else if (q.wr) begin
                        d.dout = (q.by == BY_HI) ? q.wdata[WORD_W-1:BYTE_W]
                                                 : q.wdata[BYTE_W-1:0];
                    end
                end
            end
            ST_SET: begin
                if (ph_last) begin
                    d.st       = ST_STB;
                    d.stb      = 1'b1;
                    ph_restart = 1'b1;
                end
            end
            ST_STB: begin
                if (ph_last) begin
                    ph_restart = 1'b1;
                    if (!q.wr && q.by == BY_HI) d.rd_acc[WORD_W-1:BYTE_W] = bus_din;
                    if (!q.wr && q.by == BY_LO) d.rd_acc[BYTE_W-1:0]      = bus_din;
                    if (q.by == BY_LO) begin
                        d.st    = ST_CHK;
                        d.sel_n = 1'b1;
                    end else begin
                        d.st   = ST_CLR;
                        d.by   = (q.by == BY_ADDR) ? BY_HI : BY_LO;
                        d.stb  = 1'b0;
                        d.lat  = 1'b0;
                        d.dout = '0;
                        if (!q.wr) d.doe = 1'b0;
                    end
                end
            end
            ST_CHK: begin
                if (ph_last) begin
                    if (!bus_wait) begin
                        finish = 1'b1;
                    end else if (retry_at_limit) begin
                        finish  = 1'b1;
                        fin_err = 1'b1;
                    end else begin
                        retry_inc  = 1'b1;
                        ph_restart = 1'b1;
                        d.sel_n    = 1'b0;
                        if (q.wr) begin
                            d.st = ST_PULSE;
                        end else begin
                            d.st   = ST_CLR;
                            d.by   = BY_HI;
                            d.stb  = 1'b0;
                            d.lat  = 1'b0;
                            d.dout = '0;
                        end
                    end
                end
            end
            ST_PULSE: begin
                if (ph_last) begin
                    d.st       = ST_CHK;
                    d.sel_n    = 1'b1;
                    ph_restart = 1'b1;
                end
            end
            default: d.st = ST_IDLE;
        endcase

        if (finish) begin
            d.st    = ST_IDLE;
            d.done  = 1'b1;
            d.err   = fin_err;
            d.sel_n = 1'b1;
            d.stb   = 1'b0;
            d.lat   = 1'b0;
            d.doe   = 1'b1;
            d.dout  = '1;
            if (!q.wr) d.rdata = q.rd_acc;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q       <= '0;
            q.sel_n <= 1'b1;
            q.doe   <= 1'b1;
            q.dout  <= '1;
        end else begin
            q <= d;
        end
    end

    assign busy      = (q.st != ST_IDLE);
    assign done      = q.done;
    assign error     = q.err;
    assign rdata     = q.rdata;
    assign bus_dout  = q.dout;
    assign bus_doe   = q.doe;
    assign bus_sel_n = q.sel_n;
    assign bus_dir   = q.dir;
    assign bus_stb   = q.stb;
    assign bus_lat   = q.lat;
endmodule

// File: rtl/strobe_bus_master.sv
module strobe_bus_master #(
    parameter int HOLD_CLKS = 2,
    parameter int MAX_RETRY = 3
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        req_start,
    input  logic        req_write,
    input  logic [7:0]  req_addr,
    input  logic [15:0] req_wdata,
    output logic        busy,
    output logic        done,
    output logic        error,
    output logic [15:0] rdata,
    output logic [7:0]  bus_dout,
    output logic        bus_doe,
    input  logic [7:0]  bus_din,
    output logic        bus_sel_n,
    output logic        bus_dir,
    output logic        bus_stb,
    output logic        bus_lat,
    input  logic        bus_wait
);
    logic ph_last, ph_restart;
    logic retry_clr, retry_inc, retry_at_limit;

    sbm_hold_timer #(.HOLD_CLKS(HOLD_CLKS)) u_timer (
        .clk     (clk),
        .rst_n   (rst_n),
        .restart (ph_restart),
        .last    (ph_last)
    );

    sbm_retry_count #(.MAX_RETRY(MAX_RETRY)) u_retry (
        .clk      (clk),
        .rst_n    (rst_n),
        .clr      (retry_clr),
        .inc      (retry_inc),
        .at_limit (retry_at_limit)
    );

    sbm_sequencer u_seq (
        .clk            (clk),
        .rst_n          (rst_n),
        .req_start      (req_start),
        .req_write      (req_write),
        .req_addr       (req_addr),
        .req_wdata      (req_wdata),
        .bus_din        (bus_din),
        .bus_wait       (bus_wait),
        .ph_last        (ph_last),
        .retry_at_limit (retry_at_limit),
        .ph_restart     (ph_restart),
        .retry_clr      (retry_clr),
        .retry_inc      (retry_inc),
        .busy           (busy),
        .done           (done),
        .error          (error),
        .rdata          (rdata),
        .bus_dout       (bus_dout),
        .bus_doe        (bus_doe),
        .bus_sel_n      (bus_sel_n),
        .bus_dir        (bus_dir),
        .bus_stb        (bus_stb),
        .bus_lat        (bus_lat)
    );
endmodule

// File: rtl/sbm_checker.sv
module sbm_checker (
    input logic        clk,
    input logic        rst_n,
    input logic        req_start,
    input logic        busy,
    input logic        done,
    input logic        error,
    input logic [15:0] rdata,
    input logic [7:0]  bus_dout,
    input logic        bus_doe,
    input logic        bus_sel_n,
    input logic        bus_dir,
    input logic        bus_stb,
    input logic        bus_lat
);
    AST_ACCEPT_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy && req_start) |=> busy); // R2

    AST_DIR_HELD: assert property (@(posedge clk) disable iff (!rst_n)
        busy |=> (!busy || $stable(bus_dir))); // R3

    AST_LAT_DRIVEN: assert property (@(posedge clk) disable iff (!rst_n)
        bus_lat |-> (bus_doe && !bus_sel_n)); // R5

    AST_INPUT_ONLY_READ: assert property (@(posedge clk) disable iff (!rst_n)
        !bus_doe |-> (!bus_dir && busy)); // R7

    AST_ERR_WITH_DONE: assert property (@(posedge clk) disable iff (!rst_n)
        error |-> done); // R11

    AST_DONE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done); // R12

    AST_DONE_IDLE_PINS: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> (!busy && bus_sel_n && !bus_stb && !bus_lat && bus_doe && bus_dout == 8'hFF)); // R12

    AST_RDATA_HELD: assert property (@(posedge clk) disable iff (!rst_n)
        !done |-> $stable(rdata)); // R12
endmodule

bind strobe_bus_master sbm_checker u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .req_start (req_start),
    .busy      (busy),
    .done      (done),
    .error     (error),
    .rdata     (rdata),
    .bus_dout  (bus_dout),
    .bus_doe   (bus_doe),
    .bus_sel_n (bus_sel_n),
    .bus_dir   (bus_dir),
    .bus_stb   (bus_stb),
    .bus_lat   (bus_lat)
);

// File: tb/sim_strobe_bus_master.sv
module sim_strobe_bus_master;
    localparam int H    = 2;
    localparam int MAXR = 3;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req_start = 1'b0;
    logic        req_write = 1'b0;
    logic [7:0]  req_addr = 8'h00;
    logic [15:0] req_wdata = 16'h0000;
    logic [7:0]  bus_din = 8'h00;
    logic        bus_wait = 1'b0;
    logic        busy, done, error, bus_doe, bus_sel_n, bus_dir, bus_stb, bus_lat;
    logic [15:0] rdata;
    logic [7:0]  bus_dout;

    always #4 clk = ~clk;

    strobe_bus_master #(.HOLD_CLKS(H), .MAX_RETRY(MAXR)) u0 (
        .clk(clk), .rst_n(rst_n), .req_start(req_start), .req_write(req_write),
        .req_addr(req_addr), .req_wdata(req_wdata), .busy(busy), .done(done),
        .error(error), .rdata(rdata), .bus_dout(bus_dout), .bus_doe(bus_doe),
        .bus_din(bus_din), .bus_sel_n(bus_sel_n), .bus_dir(bus_dir),
        .bus_stb(bus_stb), .bus_lat(bus_lat), .bus_wait(bus_wait)
    );

    int checks = 0;
    int fails  = 0;

    // expected per-cycle trace
    logic [15:0] qv[$];
    logic [15:0] qr[$];
    string       qt[$];
    logic [15:0] cur_rd = 16'h0000;
    logic        idle_dir = 1'b0;
    string       tag_ovr = "";

    // target model state
    int          busy_left = 0;
    bit          seen_chk = 1'b0;
    int          stb_n = 0;
    logic [15:0] rd_base = 16'h0000;
    logic        prev_sel = 1'b1;
    logic        prev_stb = 1'b0;

    function automatic logic [15:0] mk(logic b, logic dn, logic er, logic dr, logic sn,
                                       logic sb, logic lt, logic oe, logic [7:0] dv);
        return {b, dn, er, dr, sn, sb, lt, oe, dv};
    endfunction

    task automatic put(logic [15:0] v, int n, string t);
        repeat (n) begin
            qv.push_back(v);
            qr.push_back(cur_rd);
            qt.push_back((tag_ovr != "") ? tag_ovr : t);
        end
    endtask

    task automatic rd_bytes(string t);
        repeat (2) begin
            put(mk(1, 0, 0, 0, 0, 0, 0, 0, 8'h00), H, t);
            put(mk(1, 0, 0, 0, 0, 0, 0, 0, 8'h00), H, t);
            put(mk(1, 0, 0, 0, 0, 1, 0, 0, 8'h00), H, t);
        end
    endtask

    task automatic build(bit w, logic [7:0] a, logic [15:0] v, int nb);
        int k = 0;
        bit err = 1'b0;
        put(mk(1, 0, 0, w, 1, 0, 0, 1, 8'hFF), H, "R3");
        put(mk(1, 0, 0, w, 0, 0, 0, 1, 8'h00), H, "R4");
        put(mk(1, 0, 0, w, 0, 0, 1, 1, a), H, "R5");
        put(mk(1, 0, 0, w, 0, 1, 1, 1, a), H, "R5");
        if (w) begin
            put(mk(1, 0, 0, 1, 0, 0, 0, 1, 8'h00), H, "R4");
            put(mk(1, 0, 0, 1, 0, 0, 0, 1, v[15:8]), H, "R6");
            put(mk(1, 0, 0, 1, 0, 1, 0, 1, v[15:8]), H, "R6");
            put(mk(1, 0, 0, 1, 0, 0, 0, 1, 8'h00), H, "R4");
            put(mk(1, 0, 0, 1, 0, 0, 0, 1, v[7:0]), H, "R6");
            put(mk(1, 0, 0, 1, 0, 1, 0, 1, v[7:0]), H, "R6");
        end else begin
            rd_bytes("R7");
        end
        while (1) begin
            put(mk(1, 0, 0, w, 1, 1, 0, w, w ? v[7:0] : 8'h00), H, "R8");
            if (k >= nb) break;
            if (k == MAXR) begin
                err = 1'b1;
                break;
            end
            if (w) put(mk(1, 0, 0, 1, 0, 1, 0, 1, v[7:0]), H, "R9");
            else   rd_bytes("R10");
            k++;
        end
        if (!w) cur_rd = rd_base + 16'(k);
        put(mk(0, 1, err, w, 1, 0, 0, 1, 8'hFF), 1, err ? "R11" : "R12");
        idle_dir = w;
    endtask

    task automatic run(bit w, logic [7:0] a, logic [15:0] v, int nb, bit inj);
        @(negedge clk);
        #1;
        busy_left = nb;
        seen_chk  = 1'b0;
        stb_n     = 0;
        rd_base   = v;
        tag_ovr   = inj ? "R2" : "";
        build(w, a, v, nb);
        req_start = 1'b1;
        req_write = w;
        req_addr  = a;
        req_wdata = v;
        @(negedge clk);
        #1 req_start = 1'b0;
        if (inj) begin
            repeat (5) @(negedge clk);
            #1;
            req_start = 1'b1;
            req_write = !w;
            req_addr  = 8'hEE;
            req_wdata = 16'h5A5A;
            @(negedge clk);
            #1 req_start = 1'b0;
        end
        while (qv.size() > 0) @(negedge clk);
        tag_ovr = "";
    endtask

    // target response model
    always @(negedge clk) begin
        if (rst_n) begin
            if (prev_sel && !bus_sel_n && seen_chk && busy_left > 0) busy_left--;
            if (!prev_sel && bus_sel_n) seen_chk = 1'b1;
            if (!prev_stb && bus_stb && !bus_doe) begin
                logic [15:0] word;
                word = rd_base + 16'(stb_n / 2);
                bus_din = (stb_n % 2 == 0) ? word[15:8] : word[7:0];
                stb_n++;
            end
            bus_wait = (busy_left > 0);
            prev_sel = bus_sel_n;
            prev_stb = bus_stb;
        end
    end

    // per-cycle comparison
    always @(negedge clk) begin
        if (rst_n) begin
            logic [15:0] ev;
            logic [15:0] er;
            logic [15:0] act;
            string       t;
            if (qv.size() > 0) begin
                ev = qv.pop_front();
                er = qr.pop_front();
                t  = qt.pop_front();
            end else begin
                ev = mk(0, 0, 0, idle_dir, 1, 0, 0, 1, 8'hFF);
                er = cur_rd;
                t  = "R1";
            end
            act = {busy, done, error, bus_dir, bus_sel_n, bus_stb, bus_lat, bus_doe, bus_dout};
            checks++;
            if (act !== ev) begin
                fails++;
                $display("FAIL %s pins {busy,done,err,dir,sel_n,stb,lat,oe,dout} act=%h exp=%h at %0t",
                         t, act, ev, $time);
            end
            checks++;
            if (rdata !== er) begin
                fails++;
                $display("FAIL %s rdata act=%h exp=%h at %0t", t, rdata, er, $time);
            end
        end
    end

    initial begin
        repeat (150000) @(posedge clk);
        fails++;
        $display("FAIL R12 watchdog expired act=running exp=finished");
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        #1 rst_n = 1'b1;
        repeat (3) @(negedge clk);
        run(1'b1, 8'h12, 16'hBEEF, 0, 1'b0);  // R6 plain write
        run(1'b0, 8'h34, 16'h1234, 0, 1'b0);  // R7 plain read
        run(1'b1, 8'h56, 16'hA55A, 2, 1'b0);  // R9 write retries
        run(1'b0, 8'h78, 16'h0F0F, 1, 1'b0);  // R10 read retry
        run(1'b0, 8'h9A, 16'h7FFE, 5, 1'b0);  // R11 read error
        run(1'b1, 8'hBC, 16'h0001, 4, 1'b0);  // R11 write error
        run(1'b1, 8'hC3, 16'h8001, 0, 1'b1);  // R2 start ignored while busy
        run(1'b0, 8'hDE, 16'hFFFE, 3, 1'b0);  // R10 exactly at retry limit
        run(1'b0, 8'h01, 16'h00FF, 0, 1'b1);  // R2 during read
        repeat (4) @(negedge clk);
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end
endmodule